// File: doc/BRIEF.md
# Two-Class Packet Transmit Scheduler

This block sits between a source of packet descriptors and a packet transmitter. Each descriptor carries a 16-bit tag, an urgent flag and a last-of-chain flag. It goes into one of two 16-entry FIFOs, one for urgent packets and one for standard packets. The scheduler hands the transmitter one packet at a time as a one-cycle issue strobe. It then waits for the transmitter's done pulse before it chooses again. The FIFOs keep arrival order, so urgent traffic is always served first come first served.

Urgent packets take over at the boundary of a single packet, not at the end of a chain. A standard chain can be interrupted between any two of its packets. Urgent packets that arrive while earlier urgent packets are still going out queue up behind them, and all of them are sent before standard traffic continues. The interrupted standard chain then resumes with the packet at the head of the standard FIFO, which is exactly where it stopped. The last-of-chain flag goes to the transmitter unchanged. A packet that has been issued is never aborted.

The control is a two-state machine. `ST_IDLE` means nothing is outstanding, and it decides on every cycle. `ST_WAIT_DONE` means one packet is with the transmitter, and it decides only on the cycle the done pulse is seen. The transitions are:
- launch: `ST_IDLE` to `ST_WAIT_DONE` when a descriptor is available.
- chain-on: `ST_WAIT_DONE` to `ST_WAIT_DONE` on done with another descriptor available.
- drain: `ST_WAIT_DONE` to `ST_IDLE` on done with nothing available.

A descriptor accepted in the decision cycle counts as available, and it can be issued straight away without being stored.

Top module: `txsched_top`

## Requirements
- R1: `desc_ready` is high exactly when the FIFO of the offered class (urgent if `desc_urgent`=1, standard otherwise) holds fewer than 16 entries. A descriptor that is not accepted is held by the source and is never lost.
- R2: `std_empty`/`urg_empty` are high when the class holds no waiting descriptors, and `std_full`/`urg_full` are high when it holds 16. A descriptor issued in the cycle it is accepted is never counted.
- R3: After an issue strobe, no further strobe occurs until a `tx_done` pulse has been sampled.
- R4: `issue_stb` is high for one cycle. It follows the decision cycle by exactly one clock: a cycle in `ST_IDLE`, or a cycle with `tx_done` in `ST_WAIT_DONE`, in which a descriptor is available.
- R5: If any urgent descriptor is available in a decision cycle, an urgent descriptor is issued (`issue_urgent`=1), whatever standard descriptors are waiting.
- R6: Within each class, descriptors are issued in acceptance order, with their tags unchanged.
- R7: An urgent arrival interrupts a standard chain at the next packet boundary. The chain resumes with its next unsent packet once no urgent descriptor remains, and `issue_last` reproduces each packet's last-of-chain flag.
- R8: A descriptor accepted in the same cycle as `tx_done` takes part in that cycle's decision.
- R9: A `tx_done` pulse while in `ST_IDLE` has no effect on issue or flags.
- R10: After reset, no strobe is issued, both FIFOs read empty and not full, and `desc_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor accepted this cycle when valid |
| desc_urgent | input | 1 | 1 = urgent class, 0 = standard class |
| desc_last | input | 1 | 1 = last packet of its chain |
| desc_tag | input | 16 | Descriptor tag |
| issue_stb | output | 1 | One-cycle issue strobe to the transmitter |
| issue_tag | output | 16 | Tag of the issued packet |
| issue_urgent | output | 1 | Class of the issued packet |
| issue_last | output | 1 | Last-of-chain flag of the issued packet |
| tx_done | input | 1 | Transmitter finished the issued packet |
| std_full | output | 1 | Standard FIFO holds 16 |
| std_empty | output | 1 | Standard FIFO holds none |
| urg_full | output | 1 | Urgent FIFO holds 16 |
| urg_empty | output | 1 | Urgent FIFO holds none |

## Verification
The assertions assume that the transmitter never raises `tx_done` in the same cycle as `issue_stb`, and that it raises it only for a packet that is outstanding, apart from deliberate pulses while idle. The bench's transmitter model waits at least one cycle after each strobe it sees before answering. Its stray pulses are only given when the reference model is idle. The source holds each descriptor until `desc_ready` takes it, so every accepted descriptor is one that the FIFO has room for.

// File: rtl/txsched_pkg.sv
package txsched_pkg;
    parameter int TAG_W = 16;

    typedef struct packed {
        logic             last;
        logic [TAG_W-1:0] tag;
    } desc_t;

    typedef enum logic [0:0] {
        ST_IDLE      = 1'b0,
        ST_WAIT_DONE = 1'b1
    } st_e;
endpackage

// File: rtl/txsched_fifo.sv
module txsched_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rp, wp;
    logic [CW-1:0] cnt;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rp  <= '0;
            wp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= step(wp);
            if (pop)  rp <= step(rp);
            unique case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    assign dout  = mem[rp];
    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
endmodule

// File: rtl/txsched_fsm.sv
module txsched_fsm
    import txsched_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tx_done,
    input  logic  in_urg,
    input  logic  in_std,
    input  logic  urg_empty,
    input  logic  std_empty,
    input  desc_t in_desc,
    input  desc_t urg_head,
    input  desc_t std_head,
    output logic  launch,
    output logic  pick_urg,
    output logic  issue_stb,
    output logic  issue_urgent,
    output desc_t issue_desc
);
    st_e   st, st_nx;
    logic  decide, urg_ok, std_ok;
    desc_t chosen;

    always_comb begin
        unique case (st)
            ST_IDLE:      decide = 1'b1;
            ST_WAIT_DONE: decide = tx_done;
        endcase
        urg_ok   = !urg_empty || in_urg;
        std_ok   = !std_empty || in_std;
        launch   = decide && (urg_ok || std_ok);
        pick_urg = urg_ok;
        if (pick_urg) chosen = urg_empty ? in_desc : urg_head;
        else          chosen = std_empty ? in_desc : std_head;
        st_nx = st;
        if (decide) st_nx = launch ? ST_WAIT_DONE : ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issue_stb    <= 1'b0;
            issue_urgent <= 1'b0;
            issue_desc   <= '0;
        end else begin
            issue_stb <= launch;
            if (launch) begin
                issue_urgent <= pick_urg;
                issue_desc   <= chosen;
            end
        end
    end
endmodule

// File: rtl/txsched_top.sv
module txsched_top
    import txsched_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             desc_valid,
    output logic             desc_ready,
    input  logic             desc_urgent,
    input  logic             desc_last,
    input  logic [TAG_W-1:0] desc_tag,
    output logic             issue_stb,
    output logic [TAG_W-1:0] issue_tag,
    output logic             issue_urgent,
    output logic             issue_last,
    input  logic             tx_done,
    output logic             std_full,
    output logic             std_empty,
    output logic             urg_full,
    output logic             urg_empty
);
    localparam int DW = $bits(desc_t);

    desc_t          in_desc, urg_head, std_head, issue_desc;
    logic [DW-1:0]  urg_dout, std_dout;
    logic           acc, in_urg, in_std, launch, pick_urg;
    logic           push_urg, pop_urg, push_std, pop_std;

    assign in_desc    = '{last: desc_last, tag: desc_tag};
    assign desc_ready = desc_urgent ? !urg_full : !std_full;
    assign acc        = desc_valid && desc_ready;
    assign in_urg     = acc && desc_urgent;
    assign in_std     = acc && !desc_urgent;

    // A descriptor taken straight to the transmitter is not stored.
    assign pop_urg  = launch && pick_urg && !urg_empty;
    assign push_urg = in_urg && !(launch && pick_urg && urg_empty);
    assign pop_std  = launch && !pick_urg && !std_empty;
    assign push_std = in_std && !(launch && !pick_urg && std_empty);

    assign urg_head = urg_dout;
    assign std_head = std_dout;

    txsched_fifo #(.DEPTH(FIFO_DEPTH), .W(DW)) i_urg_fifo (
        .clk(clk), .rst_n(rst_n), .push(push_urg), .pop(pop_urg),
        .din(in_desc), .dout(urg_dout), .empty(urg_empty), .full(urg_full)
    );

    txsched_fifo #(.DEPTH(FIFO_DEPTH), .W(DW)) i_std_fifo (
        .clk(clk), .rst_n(rst_n), .push(push_std), .pop(pop_std),
        .din(in_desc), .dout(std_dout), .empty(std_empty), .full(std_full)
    );

    txsched_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .tx_done(tx_done),
        .in_urg(in_urg), .in_std(in_std),
        .urg_empty(urg_empty), .std_empty(std_empty),
        .in_desc(in_desc), .urg_head(urg_head), .std_head(std_head),
        .launch(launch), .pick_urg(pick_urg),
        .issue_stb(issue_stb), .issue_urgent(issue_urgent),
        .issue_desc(issue_desc)
    );

    assign issue_tag  = issue_desc.tag;
    assign issue_last = issue_desc.last;
endmodule

// File: rtl/txsched_chk.sv
module txsched_chk (
    input logic clk,
    input logic rst_n,
    input logic desc_valid,
    input logic desc_ready,
    input logic desc_urgent,
    input logic tx_done,
    input logic issue_stb,
    input logic issue_urgent,
    input logic std_full,
    input logic std_empty,
    input logic urg_full,
    input logic urg_empty
);
    AST_NO_ACCEPT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && std_full && !desc_urgent) |-> !desc_ready); // R1

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(std_full && std_empty) && !(urg_full && urg_empty)); // R2

    AST_FULL_ONLY_BY_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(std_full) |-> $past(desc_valid && desc_ready && !desc_urgent)); // R2

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        issue_stb |=> !issue_stb); // R3

    AST_URGENT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_stb && !issue_urgent) |-> $past(urg_empty)); // R5

    AST_NO_DONE_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n)
        issue_stb |-> !tx_done); // R3
endmodule

bind txsched_top txsched_chk i_chk (.*);

// File: tb/test_txsched_top.sv
module test_txsched_top;
    typedef struct { bit u; bit l; bit [15:0] t; } d_s;

    logic        clk = 0, rst_n = 0;
    logic        desc_valid = 0, desc_urgent = 0, desc_last = 0, tx_done = 0;
    logic [15:0] desc_tag = 0;
    logic        desc_ready, issue_stb, issue_urgent, issue_last;
    logic [15:0] issue_tag;
    logic        std_full, std_empty, urg_full, urg_empty;

    txsched_top i_txsched_top (.*);

    always #2 clk = ~clk;

    int n_tests = 0, n_fail = 0;
    d_s srcq[$], uq[$], sq[$];
    int tag_log[$];
    bit m_busy = 0, auto_tx = 1, pulse_done = 0;
    int tx_cnt = 0, lat_lo = 1, lat_hi = 1;
    bit e_stb = 0, e_urg = 0, e_last = 0;
    bit [15:0] e_tag = 0;
    string e_req = "R10";

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            uq.delete(); sq.delete(); m_busy = 0; tx_cnt = 0; tx_done = 0; desc_valid = 0;
            e_stb = 0;
        end else begin
            // per-cycle comparison with the reference model
            chk(issue_stb == e_stb, e_req, "issue_stb", issue_stb, e_stb);
            if (e_stb && issue_stb) begin
                chk(issue_urgent == e_urg, "R5", "issue_urgent", issue_urgent, e_urg);
                chk(issue_tag == e_tag, "R6", "issue_tag", issue_tag, e_tag);
                chk(issue_last == e_last, "R7", "issue_last", issue_last, e_last);
            end
            chk(std_empty == (sq.size() == 0), "R2", "std_empty", std_empty, sq.size() == 0);
            chk(urg_empty == (uq.size() == 0), "R2", "urg_empty", urg_empty, uq.size() == 0);
            chk(std_full == (sq.size() == 16), "R2", "std_full", std_full, sq.size() == 16);
            chk(urg_full == (uq.size() == 16), "R2", "urg_full", urg_full, uq.size() == 16);
            if (issue_stb) tag_log.push_back(int'(issue_tag));
            // transmitter model
            tx_done = 0;
            if (tx_cnt == 1) tx_done = 1;
            if (tx_cnt > 0) tx_cnt--;
            if (pulse_done) begin tx_done = 1; pulse_done = 0; end
            if (issue_stb && auto_tx) tx_cnt = $urandom_range(lat_hi, lat_lo);
            // source
            if (srcq.size() > 0) begin
                desc_valid = 1; desc_urgent = srcq[0].u; desc_last = srcq[0].l; desc_tag = srcq[0].t;
            end else begin
                desc_valid = 0; desc_urgent = 1'($urandom); desc_last = 0; desc_tag = 16'hdead;
            end
            #1;
            begin
                bit exp_rdy, decide;
                d_s d;
                exp_rdy = desc_urgent ? (uq.size() < 16) : (sq.size() < 16);
                chk(desc_ready == exp_rdy, "R1", "desc_ready", desc_ready, exp_rdy);
                if (desc_valid && exp_rdy) begin
                    d = srcq.pop_front();
                    if (d.u) uq.push_back(d); else sq.push_back(d);
                end
                decide = !m_busy || tx_done;
                if (decide && (uq.size() > 0 || sq.size() > 0)) begin
                    d = (uq.size() > 0) ? uq.pop_front() : sq.pop_front();
                    e_stb = 1; e_urg = d.u; e_tag = d.t; e_last = d.l; m_busy = 1;
                    e_req = tx_done ? "R8" : "R4";
                end else begin
                    e_req = m_busy && !tx_done ? "R3" : (tx_done && !m_busy ? "R9" : "R4");
                    e_stb = 0;
                    if (decide) m_busy = 0;
                end
            end
        end
    end

    task automatic push_d(input bit u, input bit l, input int t);
        d_s d;
        d.u = u; d.l = l; d.t = 16'(t);
        srcq.push_back(d);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic chk_log(input string req, input int exp[$]);
        chk(tag_log.size() == exp.size(), req, "log length", tag_log.size(), exp.size());
        foreach (exp[k]) if (k < tag_log.size())
            chk(tag_log[k] == exp[k], req, "log order", tag_log[k], exp[k]);
    endtask

    task automatic fill(input bit u, input int base);
        auto_tx = 0;
        for (int k = 0; k < 18; k++) push_d(u, k == 17, base + k);
        wait_cyc(30);
        #1;
        if (u) chk(urg_full == 1, "R2", "urg_full after fill", urg_full, 1);
        else   chk(std_full == 1, "R2", "std_full after fill", std_full, 1);
        chk(desc_ready == 0, "R1", "ready while full", desc_ready, 0);
        chk(srcq.size() == 1, "R1", "held descriptors", srcq.size(), 1);
        auto_tx = 1; lat_lo = 1; lat_hi = 1;
        pulse_done = 1;   // release the outstanding packet
        wait_cyc(60);
    endtask

    initial begin
        wait_cyc(4);
        #1;
        chk(issue_stb == 0, "R10", "issue_stb in reset", issue_stb, 0);
        chk(std_empty && urg_empty, "R10", "empty in reset", std_empty && urg_empty, 1);
        chk(!std_full && !urg_full, "R10", "full in reset", std_full || urg_full, 0);
        chk(desc_ready == 1, "R10", "ready in reset", desc_ready, 1);
        @(negedge clk); rst_n = 1;
        wait_cyc(3);

        // basic issue (R4)
        lat_lo = 2; lat_hi = 2;
        push_d(0, 1, 'h11);
        wait_cyc(10);

        // preemption of a standard chain (R7)
        tag_log.delete();
        lat_lo = 3; lat_hi = 3;
        for (int k = 0; k < 4; k++) push_d(0, k == 3, 'h100 + k);
        wait (tag_log.size() > 0);
        @(posedge clk);
        push_d(1, 0, 'h200); push_d(1, 1, 'h201);
        wait_cyc(40);
        chk_log("R7", '{'h100, 'h200, 'h201, 'h101, 'h102, 'h103});

        // arrival together with done (R8)
        tag_log.delete();
        auto_tx = 0;
        push_d(0, 0, 'h300); push_d(0, 1, 'h301);
        wait_cyc(6);
        push_d(1, 1, 'h3a0); pulse_done = 1;
        wait_cyc(5); pulse_done = 1;
        wait_cyc(5); pulse_done = 1;
        wait_cyc(5);
        chk_log("R8", '{'h300, 'h3a0, 'h301});

        // full FIFOs hold off the source (R1, R2)
        fill(1, 'h500);
        fill(0, 'h400);

        // stray done while idle (R9)
        tag_log.delete();
        pulse_done = 1;
        wait_cyc(4);
        #1;
        chk(tag_log.size() == 0, "R9", "issues after idle done", tag_log.size(), 0);
        chk(std_empty && urg_empty, "R9", "flags after idle done", std_empty && urg_empty, 1);

        // mixed traffic
        auto_tx = 1; lat_lo = 1; lat_hi = 5;
        for (int k = 0; k < 1500; k++) begin
            @(posedge clk);
            if ($urandom_range(0, 2) == 0 && srcq.size() < 4)
                push_d(1'($urandom_range(0, 3) == 0), 1'($urandom), 'h1000 + k);
        end
        wait_cyc(200);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL all watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule